// File: doc/BRIEF.md
# Coprocessor Context Save/Restore Controller

This block lets a host processor suspend and later reload the internal state of a slave coprocessor during a task switch. The block is a pure slave. On a save command it looks at the coprocessor's condition and streams out a frame of 32-bit words through a read port. The frame is one of three kinds: empty after reset, idle between operations, or busy in the middle of an operation. Its length depends on that condition, so the frame is only as large as the condition needs. On a restore command it takes a frame through a write port. Depending on the frame, it then returns to power-on defaults, reloads the register file, or reloads the intermediate execution state and carries on with the suspended operation.

A small execution unit stands in for the real datapath. It has a register file of `IDLE_LEN-1` words and a multi-cycle operation that adds an operand to an accumulator once per cycle for a programmed number of cycles. When the count runs out, it writes the product into a destination register. A running operation can only be frozen at checkpoints, which are the cycles where the remaining count is a multiple of `CKPT`. An operation whose remaining count is already below the busy frame length is allowed to finish, and the smaller idle frame is saved instead.

Top module: `cpctx_top`

## Requirements
- R1: After reset the context state is empty (ctx_state = 0), no transfer is active, rd_valid, wr_ready, exec_busy and proto_err are all 0, and every register holds 0.
- R2: Word 0 of every frame is a format word. Bits 31:28 hold the kind (0 empty, 1 idle, 2 busy), bits 7:0 hold the frame length, and bits 27:8 are zero. Then come registers 0 to IDLE_LEN-2. A busy frame continues with the accumulator, the operand, the remaining count and the destination index, then zero words up to BUSY_LEN.
- R3: A save in the empty state produces exactly one word, 0x00000001.
- R4: A save in the idle state produces IDLE_LEN words. An op_start with a nonzero length, accepted while nothing runs and no transfer is active, writes operand*length (modulo 2^32) into the destination register. A length of 0 is ignored.
- R5: If a save finds an operation running with at least BUSY_LEN cycles left, the operation continues until the remaining count is a multiple of CKPT and at least BUSY_LEN. It then freezes and a BUSY_LEN-word busy frame is sent. After the last word the operation is abandoned and the state is idle (ctx_state = 1).
- R6: If a save finds an operation running that reaches completion before such a checkpoint, the operation completes first and an idle frame containing the result is sent.
- R7: Restoring an empty frame (0x00000001) returns every register and the execution state to the reset defaults and sets ctx_state = 0. Restoring an idle frame loads the register file and sets ctx_state = 1.
- R8: Restoring a busy frame reloads the registers and the intermediate state. The operation then resumes (ctx_state = 2) and finishes with the same result as an uninterrupted run.
- R9: A restore whose format word has an unknown kind, nonzero bits 27:8, or a length that does not match its kind ends after that word. It sets proto_err, which stays set until reset, and leaves the registers and state unchanged.
- R10: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data holds its value.
- R11: save_req and restore_req are ignored while a frame is in progress. op_start is ignored while an operation runs.
- R12: rd_valid and wr_ready are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_start | input | 1 | Start a stand-in operation |
| op_dst | input | IDX_W | Destination register index |
| op_operand | input | 32 | Operand added each cycle |
| op_len | input | CNT_W | Operation length in cycles |
| save_req | input | 1 | Command: emit a state frame |
| restore_req | input | 1 | Command: accept a state frame |
| rd_valid | output | 1 | Frame word available |
| rd_ready | input | 1 | Host takes the frame word |
| rd_data | output | 32 | Frame word out |
| wr_valid | input | 1 | Host offers a frame word |
| wr_ready | output | 1 | Block accepts a frame word |
| wr_data | input | 32 | Frame word in |
| xfer_active | output | 1 | A save or restore frame is in progress |
| exec_busy | output | 1 | An operation is running |
| ctx_state | output | 2 | 0 empty, 1 idle, 2 busy |
| proto_err | output | 1 | Sticky bad-format flag |

## Verification
The bench builds the block with IDLE_LEN = 5, BUSY_LEN = 12, CKPT = 4 and CNT_W = 8. With these values, operation lengths of only 11 to 20 cycles land on either side of the complete-or-suspend boundary: a save can see the remaining count exactly equal to the busy frame length, or see it just short of a checkpoint. The smaller frames also let each row compare every word of a frame, including the zero padding, against a register model. A busy frame captured by a save is written back to check that the operation resumes and produces the same product as an uninterrupted run.

// File: rtl/cpctx_pkg.sv
// Package cpctx_pkg: shared frame kinds, sequencer states and the format
// word encoder for the context save/restore controller.
package cpctx_pkg;

    typedef enum logic [3:0] {
        FR_NULL = 4'h0,
        FR_IDLE = 4'h1,
        FR_BUSY = 4'h2
    } frame_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EMIT,
        ST_RHDR,
        ST_RBODY
    } seq_state_t;

    localparam logic [1:0] CTX_NULL = 2'd0;
    localparam logic [1:0] CTX_IDLE = 2'd1;
    localparam logic [1:0] CTX_BUSY = 2'd2;

    // Build the leading word of a frame from its kind and word count.
    function automatic logic [31:0] fmt_word(input frame_kind_t kind, input logic [7:0] len);
        return {kind, 20'h0, len};
    endfunction

endpackage

// File: rtl/cpctx_exec.sv
// Module cpctx_exec: stand-in execution unit. It holds NREG data registers
// plus the intermediate state of one multi-cycle operation (accumulator,
// operand, remaining count, destination). Each unfrozen cycle it adds the
// operand to the accumulator. When the count runs out, it writes the sum
// into the destination register.
// Assumes: the sequencer never asserts ld_en, start and a running step in the
// same cycle, and clear takes priority over everything else.
module cpctx_exec #(
    parameter int NREG  = 6,
    parameter int CNT_W = 16,
    parameter int IDX_W = 3,
    parameter int WI_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_dst_i,
    input  logic [31:0]      start_opnd_i,
    input  logic [CNT_W-1:0] start_len_i,
    input  logic             freeze_i,
    input  logic             halt_i,
    input  logic             resume_i,
    input  logic             ld_en_i,
    input  logic [WI_W-1:0]  ld_idx_i,
    input  logic [31:0]      ld_data_i,
    input  logic [WI_W-1:0]  rd_idx_i,
    output logic [31:0]      rd_word_o,
    output logic             running_o,
    output logic [CNT_W-1:0] rem_o
);

    localparam logic [WI_W-1:0] IX_ACC  = WI_W'(NREG + 1);
    localparam logic [WI_W-1:0] IX_OPND = WI_W'(NREG + 2);
    localparam logic [WI_W-1:0] IX_REM  = WI_W'(NREG + 3);
    localparam logic [WI_W-1:0] IX_DST  = WI_W'(NREG + 4);

    logic [31:0]      regs_q [NREG];
    logic [31:0]      acc_q;
    logic [31:0]      opnd_q;
    logic [CNT_W-1:0] rem_q;
    logic [IDX_W-1:0] dst_q;
    logic             run_q;
    logic [31:0]      sum;

    assign sum       = acc_q + opnd_q;
    assign running_o = run_q;
    assign rem_o     = rem_q;

    // Select the state word at a frame position (position 0 is handled upstream).
    always_comb begin
        rd_word_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx_i == WI_W'(i + 1)) rd_word_o = regs_q[i];
        end
        if (rd_idx_i == IX_ACC)  rd_word_o = acc_q;
        if (rd_idx_i == IX_OPND) rd_word_o = opnd_q;
        if (rd_idx_i == IX_REM)  rd_word_o = 32'(rem_q);
        if (rd_idx_i == IX_DST)  rd_word_o = 32'(dst_q);
    end

    // Register file and operation state: reset, reload, start and step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            acc_q  <= '0;
            opnd_q <= '0;
            rem_q  <= '0;
            dst_q  <= '0;
            run_q  <= 1'b0;
        end else begin
            if (ld_en_i) begin
                for (int i = 0; i < NREG; i++) begin
                    if (ld_idx_i == WI_W'(i + 1)) regs_q[i] <= ld_data_i;
                end
                if (ld_idx_i == IX_ACC)  acc_q  <= ld_data_i;
                if (ld_idx_i == IX_OPND) opnd_q <= ld_data_i;
                if (ld_idx_i == IX_REM)  rem_q  <= ld_data_i[CNT_W-1:0];
                if (ld_idx_i == IX_DST)  dst_q  <= ld_data_i[IDX_W-1:0];
            end
            if (halt_i) begin
                run_q <= 1'b0;
            end else if (resume_i) begin
                run_q <= (rem_q != '0);
            end else if (start_i) begin
                acc_q  <= '0;
                opnd_q <= start_opnd_i;
                dst_q  <= start_dst_i;
                rem_q  <= start_len_i;
                run_q  <= 1'b1;
            end else if (run_q && !freeze_i) begin
                acc_q <= sum;
                rem_q <= rem_q - 1'b1;
                if (rem_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    for (int i = 0; i < NREG; i++) begin
                        if (dst_q == IDX_W'(i)) regs_q[i] <= sum;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cpctx_seq.sv
// Module cpctx_seq: frame sequencer. It accepts save and restore commands
// only when no frame is in progress. On a save it picks the frame kind (waiting
// for a checkpoint or for completion while an operation runs) and streams the
// frame. On a restore it checks the format word and then steers the remaining
// words into the execution unit.
// Assumes: CKPT is a power of two and BUSY_LEN >= IDLE_LEN + 4, BUSY_LEN <= 255.
module cpctx_seq
    import cpctx_pkg::*;
#(
    parameter int IDLE_LEN = 7,
    parameter int BUSY_LEN = 46,
    parameter int CKPT     = 4,
    parameter int CNT_W    = 16,
    parameter int WI_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req_i,
    input  logic             restore_req_i,
    input  logic             op_start_i,
    input  logic [CNT_W-1:0] op_len_i,
    input  logic             rd_ready_i,
    input  logic             wr_valid_i,
    input  logic [31:0]      wr_data_i,
    input  logic             running_i,
    input  logic [CNT_W-1:0] rem_i,
    input  logic [31:0]      exec_word_i,
    output logic             rd_valid_o,
    output logic [31:0]      rd_data_o,
    output logic             wr_ready_o,
    output logic             xfer_active_o,
    output logic [1:0]       ctx_state_o,
    output logic             proto_err_o,
    output logic             start_o,
    output logic             freeze_o,
    output logic             halt_o,
    output logic             resume_o,
    output logic             clear_o,
    output logic             ld_en_o,
    output logic [WI_W-1:0]  idx_o
);

    localparam logic [CNT_W-1:0] CK_MASK   = CNT_W'(CKPT - 1);
    localparam logic [CNT_W-1:0] BUSY_REM  = CNT_W'(BUSY_LEN);
    localparam logic [7:0]       IDLE_L8   = 8'(IDLE_LEN);
    localparam logic [7:0]       BUSY_L8   = 8'(BUSY_LEN);

    seq_state_t      st_q;
    frame_kind_t     kind_q;
    logic [WI_W-1:0] widx_q;
    logic            null_q;
    logic            err_q;

    logic            take_busy, last, hdr_ok_pad;
    logic            hdr_null, hdr_idle, hdr_busy;
    logic [WI_W-1:0] last_idx;
    logic [7:0]      kind_len;

    // Decide whether a running operation sits on a checkpoint worth suspending at.
    assign take_busy = running_i && (rem_i >= BUSY_REM) && ((rem_i & CK_MASK) == '0);

    // Frame length and last index for the frame kind in flight.
    always_comb begin
        case (kind_q)
            FR_IDLE: begin kind_len = IDLE_L8; last_idx = WI_W'(IDLE_LEN - 1); end
            FR_BUSY: begin kind_len = BUSY_L8; last_idx = WI_W'(BUSY_LEN - 1); end
            default: begin kind_len = 8'd1;    last_idx = '0;                  end
        endcase
    end
    assign last = (widx_q == last_idx);

    // Classify an incoming format word.
    assign hdr_ok_pad = (wr_data_i[27:8] == '0);
    assign hdr_null   = hdr_ok_pad && wr_data_i[31:28] == FR_NULL && wr_data_i[7:0] == 8'd1;
    assign hdr_idle   = hdr_ok_pad && wr_data_i[31:28] == FR_IDLE && wr_data_i[7:0] == IDLE_L8;
    assign hdr_busy   = hdr_ok_pad && wr_data_i[31:28] == FR_BUSY && wr_data_i[7:0] == BUSY_L8;

    // Port-side handshakes and the command strobes towards the execution unit.
    always_comb begin
        rd_valid_o    = (st_q == ST_EMIT);
        wr_ready_o    = (st_q == ST_RHDR) || (st_q == ST_RBODY);
        rd_data_o     = (widx_q == '0) ? fmt_word(kind_q, kind_len) : exec_word_i;
        xfer_active_o = (st_q != ST_IDLE);
        ctx_state_o   = null_q ? CTX_NULL : (running_i ? CTX_BUSY : CTX_IDLE);
        proto_err_o   = err_q;
        idx_o         = widx_q;
        start_o       = op_start_i && (st_q == ST_IDLE) && !running_i && (op_len_i != '0)
                        && !(restore_req_i && !save_req_i);
        freeze_o      = ((st_q == ST_WAIT) && !null_q && take_busy)
                        || ((st_q == ST_EMIT) && (kind_q == FR_BUSY));
        halt_o        = ((st_q == ST_EMIT) && (kind_q == FR_BUSY) && rd_ready_i && last)
                        || ((st_q == ST_RHDR) && wr_valid_i && (hdr_idle || hdr_busy));
        clear_o       = (st_q == ST_RHDR) && wr_valid_i && hdr_null;
        ld_en_o       = (st_q == ST_RBODY) && wr_valid_i;
        resume_o      = ld_en_o && last && (kind_q == FR_BUSY);
    end

    // Sequencer state, frame position, empty flag and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= FR_NULL;
            widx_q <= '0;
            null_q <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            if (start_o) null_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    widx_q <= '0;
                    if (save_req_i)         st_q <= ST_WAIT;
                    else if (restore_req_i) st_q <= ST_RHDR;
                end
                ST_WAIT: begin
                    if (null_q) begin
                        kind_q <= FR_NULL;
                        st_q   <= ST_EMIT;
                    end else if (!running_i) begin
                        kind_q <= FR_IDLE;
                        st_q   <= ST_EMIT;
                    end else if (take_busy) begin
                        kind_q <= FR_BUSY;
                        st_q   <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (rd_ready_i) begin
                        widx_q <= widx_q + 1'b1;
                        if (last) st_q <= ST_IDLE;
                    end
                end
                ST_RHDR: begin
                    if (wr_valid_i) begin
                        widx_q <= WI_W'(1);
                        if (hdr_null) begin
                            null_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else if (hdr_idle || hdr_busy) begin
                            kind_q <= hdr_busy ? FR_BUSY : FR_IDLE;
                            st_q   <= ST_RBODY;
                        end else begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end
                    end
                end
                ST_RBODY: begin
                    if (wr_valid_i) begin
                        widx_q <= widx_q + 1'b1;
                        if (last) begin
                            null_q <= 1'b0;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cpctx_top.sv
// Module cpctx_top: context save/restore controller for a slave coprocessor.
// It joins the frame sequencer to the stand-in execution unit. Restore words
// go straight into the execution unit, and saved words are read from it.
// Assumes: the host moves every frame word through the valid/ready ports;
// the block never starts a transfer on its own.
module cpctx_top #(
    parameter int IDLE_LEN = 7,
    parameter int BUSY_LEN = 46,
    parameter int CKPT     = 4,
    parameter int CNT_W    = 16,
    localparam int NREG    = IDLE_LEN - 1,
    localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int WI_W    = $clog2(BUSY_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic [IDX_W-1:0] op_dst,
    input  logic [31:0]      op_operand,
    input  logic [CNT_W-1:0] op_len,
    input  logic             save_req,
    input  logic             restore_req,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [31:0]      rd_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [31:0]      wr_data,
    output logic             xfer_active,
    output logic             exec_busy,
    output logic [1:0]       ctx_state,
    output logic             proto_err
);

    logic             start_w, freeze_w, halt_w, resume_w, clear_w, ld_en_w, running_w;
    logic [WI_W-1:0]  idx_w;
    logic [CNT_W-1:0] rem_w;
    logic [31:0]      word_w;

    assign exec_busy = running_w;

    cpctx_seq #(
        .IDLE_LEN(IDLE_LEN), .BUSY_LEN(BUSY_LEN), .CKPT(CKPT),
        .CNT_W(CNT_W), .WI_W(WI_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .save_req_i(save_req), .restore_req_i(restore_req),
        .op_start_i(op_start), .op_len_i(op_len),
        .rd_ready_i(rd_ready), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
        .running_i(running_w), .rem_i(rem_w), .exec_word_i(word_w),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .wr_ready_o(wr_ready),
        .xfer_active_o(xfer_active), .ctx_state_o(ctx_state), .proto_err_o(proto_err),
        .start_o(start_w), .freeze_o(freeze_w), .halt_o(halt_w), .resume_o(resume_w),
        .clear_o(clear_w), .ld_en_o(ld_en_w), .idx_o(idx_w)
    );

    cpctx_exec #(
        .NREG(NREG), .CNT_W(CNT_W), .IDX_W(IDX_W), .WI_W(WI_W)
    ) u_exec (
        .clk(clk), .rst_n(rst_n),
        .clear_i(clear_w), .start_i(start_w),
        .start_dst_i(op_dst), .start_opnd_i(op_operand), .start_len_i(op_len),
        .freeze_i(freeze_w), .halt_i(halt_w), .resume_i(resume_w),
        .ld_en_i(ld_en_w), .ld_idx_i(idx_w), .ld_data_i(wr_data),
        .rd_idx_i(idx_w), .rd_word_o(word_w),
        .running_o(running_w), .rem_o(rem_w)
    );

endmodule

// File: rtl/cpctx_chk.sv
// Module cpctx_chk: protocol and suspension checks for cpctx_top, attached
// through the bind statement at the end of this file.
// Assumes: rem_w and freeze_w are the top-level nets between sequencer and
// execution unit.
module cpctx_chk #(
    parameter int BUSY_LEN = 46,
    parameter int CKPT     = 4,
    parameter int CNT_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [31:0]      rd_data,
    input logic             wr_ready,
    input logic             proto_err,
    input logic             freeze_w,
    input logic [CNT_W-1:0] rem_w
);

    localparam logic [CNT_W-1:0] CK_MASK  = CNT_W'(CKPT - 1);
    localparam logic [CNT_W-1:0] BUSY_REM = CNT_W'(BUSY_LEN);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_one_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_ready));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    assert_ckpt_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_w |-> (((rem_w & CK_MASK) == '0) && (rem_w >= BUSY_REM)));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_w |=> $stable(rem_w));

endmodule

bind cpctx_top cpctx_chk #(
    .BUSY_LEN(BUSY_LEN), .CKPT(CKPT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_ready(wr_ready), .proto_err(proto_err),
    .freeze_w(freeze_w), .rem_w(rem_w)
);

// File: tb/test_cpctx_top.sv
// Bench for cpctx_top: a table of operation/save vectors, then directed
// tests for reset, restore kinds, stalls, ignored commands and bad formats.
module test_cpctx_top;

    localparam int IL = 5;
    localparam int BL = 12;
    localparam int CK = 4;
    localparam int CW = 8;
    localparam int NR = IL - 1;
    localparam int IW = 2;
    localparam logic [31:0] F_NULL = 32'h0000_0001;
    localparam logic [31:0] F_IDLE = 32'h1000_0005;
    localparam logic [31:0] F_BUSY = 32'h2000_000C;

    typedef struct packed {
        logic [IW-1:0] dst;
        logic [31:0]   opnd;
        logic [7:0]    len;
        logic          busy;
        logic [7:0]    rem;
    } vec_t;

    // start + save in one cycle; busy rows give the remaining count at suspension
    localparam vec_t VEC [5] = '{
        '{2'd0, 32'd5,     8'd3,  1'b0, 8'd0},
        '{2'd1, 32'h100,   8'd11, 1'b0, 8'd0},
        '{2'd2, 32'd7,     8'd14, 1'b1, 8'd12},
        '{2'd3, 32'd3,     8'd17, 1'b1, 8'd16},
        '{2'd2, 32'd9,     8'd12, 1'b1, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic [IW-1:0] op_dst = '0;
    logic [31:0]   op_operand = '0;
    logic [CW-1:0] op_len = '0;
    logic          save_req = 1'b0, restore_req = 1'b0;
    logic          rd_valid, rd_ready = 1'b1;
    logic [31:0]   rd_data;
    logic          wr_valid = 1'b0, wr_ready;
    logic [31:0]   wr_data = '0;
    logic          xfer_active, exec_busy, proto_err;
    logic [1:0]    ctx_state;

    int          n_tests = 0, n_fail = 0;
    logic [31:0] fr [64];
    int          fr_n;
    logic [31:0] exp_reg [NR];

    always #2 clk = ~clk;

    cpctx_top #(.IDLE_LEN(IL), .BUSY_LEN(BL), .CKPT(CK), .CNT_W(CW)) i_cpctx_top (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_dst(op_dst),
        .op_operand(op_operand), .op_len(op_len), .save_req(save_req),
        .restore_req(restore_req), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .xfer_active(xfer_active), .exec_busy(exec_busy), .ctx_state(ctx_state),
        .proto_err(proto_err)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Gather frame words until the transfer ends (rd_ready assumed high).
    task automatic collect();
        fr_n = 0;
        for (int k = 0; k < 2000; k++) begin
            if (rd_valid) begin
                if (fr_n < 64) fr[fr_n] = rd_data;
                fr_n++;
            end else if (!xfer_active) begin
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_save();
        @(negedge clk); save_req = 1'b1;
        @(negedge clk); save_req = 1'b0;
        collect();
    endtask

    task automatic start_save(input logic [IW-1:0] d, input logic [31:0] o, input logic [7:0] l);
        @(negedge clk);
        op_start = 1'b1; op_dst = d; op_operand = o; op_len = l; save_req = 1'b1;
        @(negedge clk);
        op_start = 1'b0; save_req = 1'b0;
        collect();
    endtask

    task automatic start_op(input logic [IW-1:0] d, input logic [31:0] o, input logic [7:0] l);
        @(negedge clk);
        op_start = 1'b1; op_dst = d; op_operand = o; op_len = l;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 1000 && exec_busy; k++) @(negedge clk);
    endtask

    task automatic write_frame(input int n);
        @(negedge clk); restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_data = fr[i];
            for (int k = 0; k < 100 && !wr_ready; k++) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic bad_header(input logic [31:0] h);
        @(negedge clk); restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0; wr_valid = 1'b1; wr_data = h;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic check_idle_frame(input string req);
        check_eq({req, " idle length"}, 32'(fr_n), 32'(IL));
        check_eq({req, " idle format"}, fr[0], F_IDLE);
        for (int i = 0; i < NR; i++) check_eq({req, " idle reg"}, fr[1+i], exp_reg[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NR; i++) exp_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_eq("R1 ctx_state", 32'(ctx_state), 32'd0);
        check_eq("R1 xfer_active", 32'(xfer_active), 32'd0);
        check_eq("R1 rd_valid", 32'(rd_valid), 32'd0);
        check_eq("R1 wr_ready", 32'(wr_ready), 32'd0);
        check_eq("R1 exec_busy", 32'(exec_busy), 32'd0);
        check_eq("R1 proto_err", 32'(proto_err), 32'd0);

        // R3: save in the empty state gives one word
        do_save();
        check_eq("R3 null length", 32'(fr_n), 32'd1);
        check_eq("R3 null word", fr[0], F_NULL);
        check_eq("R3 still empty", 32'(ctx_state), 32'd0);

        // R4 R5 R6 R2: vector walk
        foreach (VEC[v]) begin
            start_save(VEC[v].dst, VEC[v].opnd, VEC[v].len);
            if (!VEC[v].busy) begin
                exp_reg[VEC[v].dst] = VEC[v].opnd * 32'(VEC[v].len);
                check_idle_frame("R4 R6 R2");
            end else begin
                check_eq("R5 busy length", 32'(fr_n), 32'(BL));
                check_eq("R5 R2 busy format", fr[0], F_BUSY);
                for (int i = 0; i < NR; i++) check_eq("R5 busy reg", fr[1+i], exp_reg[i]);
                check_eq("R5 busy acc", fr[IL], VEC[v].opnd * 32'(VEC[v].len - VEC[v].rem));
                check_eq("R5 busy operand", fr[IL+1], VEC[v].opnd);
                check_eq("R5 busy remaining", fr[IL+2], 32'(VEC[v].rem));
                check_eq("R5 busy dst", fr[IL+3], 32'(VEC[v].dst));
                for (int i = IL + 4; i < BL; i++) check_eq("R2 busy pad", fr[i], 32'd0);
                check_eq("R5 abandoned idle", 32'(ctx_state), 32'd1);
                check_eq("R5 not running", 32'(exec_busy), 32'd0);
            end
        end

        // R8: suspend then restore a busy frame and let it finish
        start_save(2'd1, 32'd6, 8'd20);
        check_eq("R8 captured busy", fr[0], F_BUSY);
        write_frame(BL);
        check_eq("R8 resumed busy", 32'(ctx_state), 32'd2);
        wait_done();
        exp_reg[1] = 32'd120;
        do_save();
        check_idle_frame("R8 resumed result");

        // R7: restore an idle frame with new register values
        fr[0] = F_IDLE;
        for (int i = 0; i < NR; i++) begin
            exp_reg[i] = 32'hA5A5_0000 + 32'(i);
            fr[1+i] = exp_reg[i];
        end
        write_frame(IL);
        check_eq("R7 idle after restore", 32'(ctx_state), 32'd1);
        do_save();
        check_idle_frame("R7 idle reload");

        // R10 R12: stalled read holds its word
        begin
            logic [31:0] d0;
            @(negedge clk); rd_ready = 1'b0; save_req = 1'b1;
            @(negedge clk); save_req = 1'b0;
            for (int k = 0; k < 20 && !rd_valid; k++) @(negedge clk);
            d0 = rd_data;
            repeat (3) begin
                @(negedge clk);
                check_eq("R10 valid held", 32'(rd_valid), 32'd1);
                check_eq("R10 data held", rd_data, d0);
                check_eq("R12 no write ready", 32'(wr_ready), 32'd0);
            end
            rd_ready = 1'b1;
            collect();
            check_idle_frame("R10 after stall");
        end

        // R11: second start while running is ignored; commands during a frame ignored
        start_op(2'd0, 32'd1, 8'd30);
        @(negedge clk);
        op_start = 1'b1; op_dst = 2'd3; op_operand = 32'd99; op_len = 8'd2;
        @(negedge clk); op_start = 1'b0;
        wait_done();
        exp_reg[0] = 32'd30;
        @(negedge clk); rd_ready = 1'b0; save_req = 1'b1;
        @(negedge clk); save_req = 1'b0; restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0; save_req = 1'b1;
        @(negedge clk); save_req = 1'b0; rd_ready = 1'b1;
        collect();
        check_idle_frame("R11 ignored start");
        repeat (2) begin
            @(negedge clk);
            check_eq("R11 no extra frame", 32'(xfer_active), 32'd0);
            check_eq("R11 no extra word", 32'(rd_valid), 32'd0);
        end

        // R9: bad kind, then bad length, then nonzero middle bits
        bad_header(32'h3000_0005);
        check_eq("R9 error set", 32'(proto_err), 32'd1);
        check_eq("R9 frame ended", 32'(xfer_active), 32'd0);
        bad_header(32'h1000_0006);
        bad_header(32'h1000_0105);
        check_eq("R9 error sticky", 32'(proto_err), 32'd1);
        check_eq("R9 state unchanged", 32'(ctx_state), 32'd1);
        do_save();
        check_idle_frame("R9 regs unchanged");

        // R7: empty-frame restore returns to defaults
        fr[0] = F_NULL;
        write_frame(1);
        check_eq("R7 empty state", 32'(ctx_state), 32'd0);
        check_eq("R9 error kept", 32'(proto_err), 32'd1);
        do_save();
        check_eq("R7 empty save length", 32'(fr_n), 32'd1);
        check_eq("R7 empty save word", fr[0], F_NULL);
        for (int i = 0; i < NR; i++) exp_reg[i] = '0;
        start_op(2'd2, 32'd4, 8'd0);
        check_eq("R4 zero length ignored", 32'(exec_busy), 32'd0);
        start_op(2'd2, 32'd4, 8'd1);
        wait_done();
        exp_reg[2] = 32'd4;
        do_save();
        check_idle_frame("R7 defaults");

        finish_run();
    end

endmodule